// File: doc/BRIEF.md
# Received Frame Status Queue

This block keeps one record per completed infrared receive frame so that software or a DMA engine can find where each frame ends in the received data stream and pick out frames that arrived damaged. Each time the receiver signals that a frame has finished, the block stores the frame length (12 bits) and three error flags: length error, CRC error and abort. It holds up to eight such records in arrival order.

The oldest record is always visible on the outputs. It appears as a status byte that carries the error flags, a 4-bit upper length field and an 8-bit lower length field. A one-cycle read strobe on the status byte removes that record, and the next one appears. An interrupt stays high while the number of stored records is at or above a programmable trigger level. Software is then interrupted once per batch of frames rather than once per frame.

A small controller state machine tracks the fill state. It has three states:
- `Q_EMPTY`: no records are stored. A push moves it to `Q_PARTIAL`.
- `Q_PARTIAL`: between one and seven records are stored. A push alone at a count of 7 moves it to `Q_FULL`. A read alone at a count of 1 moves it to `Q_EMPTY`. Any other event stays in `Q_PARTIAL`.
- `Q_FULL`: eight records are stored. A read alone moves it to `Q_PARTIAL`. A read together with a push stays in `Q_FULL`.

Top module: `rx_frame_status_queue`

## Requirements
- R1: After reset the queue is empty and all of the following are 0: `fill_level`, `irq`, `ovf_flag`, `stat_byte`, `len_hi` and `len_lo`.
- R2: A push stores the frame length and error flags. The stored record becomes visible on the outputs after the clock edge that accepts it, provided no older record is still queued.
- R3: `stat_byte` layout:
  - bit 0 is 1 while a record is present.
  - bit 4 is the length error, bit 3 is the CRC error and bit 2 is the abort flag.
  - bits 1, 5, 6 and 7 are always 0.
- R4: The head length is split into two fields: `len_hi` carries length bits [11:8] and `len_lo` carries length bits [7:0].
- R5: Records come out in the order they were pushed. Each read strobe on a non-empty queue removes exactly one record.
- R6: The queue accepts eight records, after which `fill_level` reads 8.
- R7: A push while full with no read in the same cycle is discarded, and it sets `ovf_flag`. `ovf_flag` stays set until the next read strobe clears it.
- R8: On an empty queue, `stat_byte`, `len_hi` and `len_lo` read 0. A read strobe on an empty queue changes neither the level nor which record the next push will expose.
- R9: `irq` is high exactly while `fill_level` is at or above the effective trigger level. The effective level is `trig_level`, with a value of 0 treated as 1 and any value above 8 treated as 8.
- R10: A push and a read in the same cycle on a non-empty queue, including a full one, both take effect and leave the level unchanged. On an empty queue only the push takes effect.
- R11: Reading until the queue is empty never takes more than eight read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Frame-complete strobe from the receiver |
| push_len | input | 12 | Length of the completed frame |
| push_err | input | 3 | Error flags {length, CRC, abort} |
| stat_rd | input | 1 | Read strobe on the status byte; removes the head record |
| trig_level | input | 4 | Interrupt trigger level in records |
| stat_byte | output | 8 | Head record status byte |
| len_hi | output | 4 | Head length bits [11:8] |
| len_lo | output | 8 | Head length bits [7:0] |
| fill_level | output | 4 | Number of stored records |
| irq | output | 1 | Level-reached interrupt |
| ovf_flag | output | 1 | Sticky flag for a discarded push |

## Verification
Every result is due one clock edge after its stimulus:
- A push or read strobe applied before edge k changes `fill_level`, the head fields, `irq` and `ovf_flag` right after edge k.
- A change to `trig_level` alone acts on `irq` in the same cycle, with no edge needed.

The bench drives each strobe at a falling edge and lets one rising edge pass. It updates a queue-based model of the records at that edge, then compares every output at the next falling edge, so each sample falls in the first cycle the result is due.

// File: rtl/rx_frame_status_pkg.sv
package rx_frame_status_pkg;

    localparam int FS_LEN_W = 12;
    localparam int FS_ERR_W = 3;

    typedef struct packed {
        logic [FS_LEN_W-1:0] len;
        logic                err_len;
        logic                err_crc;
        logic                err_abort;
    } fs_rec_t;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } fs_state_t;

endpackage

// File: rtl/fs_store.sv
module fs_store
    import rx_frame_status_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  fs_rec_t          wr_rec,
    input  logic [PTR_W-1:0] rd_ptr,
    output fs_rec_t          rd_rec
);

    fs_rec_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slots[g] <= '0;
            else if (wr_en && (wr_ptr == PTR_W'(g)))
                slots[g] <= wr_rec;
        end
    end

    assign rd_rec = slots[rd_ptr];

endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
    import rx_frame_status_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             has_rec,
    output logic             ovf
);

    fs_state_t state, state_nx;
    logic      do_push, do_pop, drop;

    always_comb begin
        do_pop  = pop && (state != Q_EMPTY);
        do_push = push && ((state != Q_FULL) || do_pop);
        drop    = push && !do_push;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            Q_EMPTY:
                if (do_push) state_nx = Q_PARTIAL;
            Q_PARTIAL: begin
                if (do_push && !do_pop && (count == CNT_W'(DEPTH - 1)))
                    state_nx = Q_FULL;
                else if (do_pop && !do_push && (count == CNT_W'(1)))
                    state_nx = Q_EMPTY;
            end
            Q_FULL:
                if (do_pop && !do_push) state_nx = Q_PARTIAL;
            default: state_nx = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (drop)     ovf <= 1'b1;
            else if (pop) ovf <= 1'b0;
        end
    end

    always_comb begin
        wr_en   = do_push;
        has_rec = (state != Q_EMPTY);
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_full_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL) == (count == CNT_W'(DEPTH)));

    assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && state == Q_EMPTY) |=> (count == '0));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && state == Q_FULL) |=> (ovf && $stable(count)));

    assert_pair_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && state != Q_EMPTY) |=> $stable(count));

endmodule

// File: rtl/fs_irq.sv
module fs_irq #(
    parameter int DEPTH  = 8,
    parameter int TRIG_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  logic [TRIG_W-1:0] trig,
    output logic              irq
);

    int eff_trig;

    always_comb begin
        if (trig == '0)                eff_trig = 1;
        else if (int'(trig) > DEPTH)   eff_trig = DEPTH;
        else                           eff_trig = int'(trig);
        irq = (int'(count) >= eff_trig);
    end

    assert_irq_needs_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count != '0));

    assert_irq_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH)) |-> irq);

endmodule

// File: rtl/rx_frame_status_queue.sv
module rx_frame_status_queue
    import rx_frame_status_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int LO_W   = 8,
    parameter int TRIG_W = 4,
    localparam int LEN_W = FS_LEN_W,
    localparam int HI_W  = LEN_W - LO_W,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [LEN_W-1:0]  push_len,
    input  logic [2:0]        push_err,
    input  logic              stat_rd,
    input  logic [TRIG_W-1:0] trig_level,
    output logic [7:0]        stat_byte,
    output logic [HI_W-1:0]   len_hi,
    output logic [LO_W-1:0]   len_lo,
    output logic [CNT_W-1:0]  fill_level,
    output logic              irq,
    output logic              ovf_flag
);

    logic             wr_en, has_rec;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    fs_rec_t          in_rec, head;

    always_comb begin
        in_rec.len       = push_len;
        in_rec.err_len   = push_err[2];
        in_rec.err_crc   = push_err[1];
        in_rec.err_abort = push_err[0];
    end

    fs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push_valid), .pop(stat_rd),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .count(fill_level), .has_rec(has_rec), .ovf(ovf_flag)
    );

    fs_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_rec(in_rec), .rd_ptr(rd_ptr), .rd_rec(head)
    );

    fs_irq #(.DEPTH(DEPTH), .TRIG_W(TRIG_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .count(fill_level),
        .trig(trig_level), .irq(irq)
    );

    always_comb begin
        if (has_rec) begin
            stat_byte = {3'b000, head.err_len, head.err_crc, head.err_abort, 1'b0, 1'b1};
            len_hi    = head.len[LEN_W-1:LO_W];
            len_lo    = head.len[LO_W-1:0];
        end else begin
            stat_byte = '0;
            len_hi    = '0;
            len_lo    = '0;
        end
    end

    assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) |-> (stat_byte == 8'h00 && len_lo == '0));

    assert_reserved_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_byte[7:5] == 3'b000) && !stat_byte[1]);

endmodule

// File: tb/rx_frame_status_queue_test.sv
module rx_frame_status_queue_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [11:0] len;
        logic [2:0]  err;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [11:0] push_len = '0;
    logic [2:0]  push_err = '0;
    logic        stat_rd = 1'b0;
    logic [3:0]  trig_level = 4'd3;
    logic [7:0]  stat_byte;
    logic [3:0]  len_hi;
    logic [7:0]  len_lo;
    logic [3:0]  fill_level;
    logic        irq;
    logic        ovf_flag;

    int    n_run = 0;
    int    n_fail = 0;
    item_t expq[$];
    logic  exp_ovf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_status_queue uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_len(push_len),
        .push_err(push_err), .stat_rd(stat_rd), .trig_level(trig_level),
        .stat_byte(stat_byte), .len_hi(len_hi), .len_lo(len_lo),
        .fill_level(fill_level), .irq(irq), .ovf_flag(ovf_flag)
    );

    function automatic int eff_trig(input logic [3:0] t);
        if (t == 0) return 1;
        if (t > 8)  return 8;
        return int'(t);
    endfunction

    task automatic cmp(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: compares all outputs against the scoreboard head
    task automatic check_all(input string req);
        logic [7:0] es;
        logic [3:0] eh;
        logic [7:0] el;
        if (expq.size() > 0) begin
            es = {3'b000, expq[0].err, 1'b0, 1'b1};
            eh = expq[0].len[11:8];
            el = expq[0].len[7:0];
        end else begin
            es = '0; eh = '0; el = '0;
        end
        cmp(req, "level", int'(fill_level), expq.size());
        cmp(req, "stat", int'(stat_byte), int'(es));
        cmp(req, "len_hi", int'(len_hi), int'(eh));
        cmp(req, "len_lo", int'(len_lo), int'(el));
        cmp(req, "irq", int'(irq), int'(expq.size() >= eff_trig(trig_level)));
        cmp(req, "ovf", int'(ovf_flag), int'(exp_ovf));
    endtask

    // driver: one strobe cycle, updates the scoreboard at the edge
    task automatic op(input logic p, input item_t it, input logic r, input string req);
        logic dpop, dpush;
        @(negedge clk);
        push_valid = p; push_len = it.len; push_err = it.err; stat_rd = r;
        @(posedge clk);
        dpop  = r && (expq.size() > 0);
        dpush = p && ((expq.size() < 8) || dpop);
        if (dpop)  void'(expq.pop_front());
        if (dpush) expq.push_back(it);
        if (p && !dpush) exp_ovf = 1'b1;
        else if (r)      exp_ovf = 1'b0;
        @(negedge clk);
        push_valid = 1'b0; stat_rd = 1'b0;
        check_all(req);
    endtask

    function automatic item_t mk(input int l, input int e);
        item_t t;
        t.len = 12'(l);
        t.err = 3'(e);
        return t;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int reads;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        op(1'b1, mk('hA5C, 3'b100), 1'b0, "R2_R4");
        op(1'b1, mk('h013, 3'b010), 1'b0, "R9");
        op(1'b1, mk('hFFF, 3'b001), 1'b0, "R9");
        op(1'b0, mk(0, 0), 1'b1, "R5");
        op(1'b0, mk(0, 0), 1'b1, "R3_R5");
        op(1'b0, mk(0, 0), 1'b1, "R8");
        op(1'b0, mk(0, 0), 1'b1, "R8");
        op(1'b1, mk('h321, 3'b111), 1'b0, "R8");

        for (int i = 1; i < 8; i++)
            op(1'b1, mk(i * 'h111, i), 1'b0, "R6");
        cmp("R6", "full level", int'(fill_level), 8);
        op(1'b1, mk('h777, 3'b101), 1'b0, "R7");
        op(1'b1, mk('h778, 3'b011), 1'b0, "R7");
        op(1'b0, mk(0, 0), 1'b1, "R7");
        op(1'b1, mk('h0AB, 3'b110), 1'b1, "R10");
        op(1'b1, mk('h0CD, 3'b000), 1'b0, "R10");
        op(1'b1, mk('h0EF, 3'b010), 1'b1, "R10");

        trig_level = 4'd15;
        @(negedge clk);
        check_all("R9");
        op(1'b0, mk(0, 0), 1'b1, "R9");

        reads = 0;
        while (fill_level != 0 && reads < 12) begin
            op(1'b0, mk(0, 0), 1'b1, "R5_R11");
            reads++;
        end
        n_run++;
        if (reads > 8) begin
            n_fail++;
            $display("FAIL R11 reads: actual %0d expected <=8", reads);
        end

        trig_level = 4'd0;
        op(1'b1, mk('h456, 3'b001), 1'b1, "R10");
        check_all("R9");
        op(1'b0, mk(0, 0), 1'b1, "R9");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule